// File: doc/BRIEF.md
# Three-Wire Timekeeper Serial Master

This block drives one transaction on a three-wire serial link to a timekeeping device. The three lines are a serial clock output, a transaction-enable output and a data line. The data line is split here into separate drive-value, drive-enable and receive ports so that the pad ring, or a testbench model of the device, can form the bidirectional pin. The host presents a command byte and, for a write, a data byte, and pulses a start request. The block then frames the transfer with a timed enable sequence and shifts the command out. Bit 0 of the command selects the direction. For a write it shifts the data byte out. For a read it releases the data line and captures one byte from the device.

All timing is counted in time units. One unit is a parameterised number of system clocks, so a unit of about one microsecond is kept at any clock rate. The prologue, the length of each bit half and the epilogue are whole numbers of units. A start request that arrives while a transfer is running has no effect. A byte that has been read stays on the result port until the host starts the next transfer.

Top module: `tw_rtc_master`

## Requirements
- R1: While reset is held and in the first cycle after it, the enable, the serial clock, the data drive-enable, busy and done are all low, and the read result is zero.
- R2: Command bits leave least significant bit first. At the n-th rising edge of the serial clock (n = 1..8) the data line carries command bit n-1 and is driven.
- R3: When command bit 0 is 0 (write), the data byte follows LSB first on rising edges 9..16 with the line driven. Exactly 16 rising edges occur in the transfer.
- R4: When command bit 0 is 1 (read), the drive-enable is low for rising edges 9..16. The receive line is sampled at the end of each clock-low unit, and each sample enters at the MSB of a right-shifting byte. The bit sampled first therefore ends up in bit 0 of the result, which appears when done is high.
- R5: After a start is accepted the serial clock stays low. The enable stays low for 1 + 5 units (6·TICK_DIV clocks) after the accepting edge and then rises. The first rising clock edge comes one unit after that.
- R6: Each bit spends one unit with the clock low, with its data already on the line, and then one unit with the clock high. The serial clock changes only on unit boundaries.
- R7: After the last clock-high unit the clock stays high for 2 more units. Then the enable and the clock fall together, 3 units after the last rising edge.
- R8: Busy is high from the accepting edge until the enable falls. Done is a single-cycle pulse in the cycle the enable falls. A start seen while busy does not restart or alter the transfer.
- R9: The read result clears to zero when a start is accepted. It changes otherwise only when a read completes, and it then holds through idle time until the next accepted start. A write leaves it at zero.
- R10: The whole transfer takes 40 units. The enable falls 40·TICK_DIV clocks after the accepting edge, for any TICK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, accepted only when idle |
| cmd_i | input | DATA_W | Command byte; bit 0 high selects read |
| wdata_i | input | DATA_W | Byte sent after the command on a write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rdata_o | output | DATA_W | Byte captured by the last read |
| ce_o | output | 1 | Transaction-enable line |
| sclk_o | output | 1 | Serial clock |
| sd_out_o | output | 1 | Data line drive value |
| sd_oe_o | output | 1 | Data line drive enable |
| sd_in_i | input | 1 | Data line receive value |

## Verification
Some rules are checked by assertions on every cycle. The serial clock moves only on unit ticks and is never high with the enable low. Done is one cycle wide and coincides with the enable falling. The prologue state is entered only from idle. The result register changes only at a completion or an accepted start. Other properties are shown by the bench's sweep over register addresses and data patterns, with a small model of the device. These are LSB-first ordering in both directions, the MSB-entry capture, the turnaround of the data line, the exact unit counts of prologue, bit halves and epilogue, and the immunity to a mid-transfer start.

// File: rtl/tw_rtc_pkg.sv
package tw_rtc_pkg;

    // Sequencer phases of one framed transfer
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,   // clock low, enable low, first unit
        PH_GAP   = 3'd2,   // enable low pulse
        PH_CLKLO = 3'd3,   // bit half with clock low
        PH_CLKHI = 3'd4,   // bit half with clock high
        PH_TAIL  = 3'd5    // hold after last clock before enable drops
    } tw_phase_e;

    // Strobes from the sequencer to the shift datapath
    typedef struct packed {
        logic load;     // accept new command / data, clear result
        logic advance;  // move to next transmit bit
        logic sample;   // capture receive line into MSB
        logic commit;   // publish captured byte
    } tw_shift_ctl_t;

    // Command bit that selects the read direction
    localparam int unsigned RD_SEL_BIT = 0;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tw_unit_timer.sv
module tw_unit_timer #(
    parameter int unsigned TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick_o
);
    localparam int unsigned CW = tw_rtc_pkg::cnt_width(TICK_DIV);

    generate
        if (TICK_DIV <= 1) begin : g_every_clock
            assign tick_o = en;
        end else begin : g_divided
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !en)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = en && (cnt_q == LAST);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o); // R10
        end
    endgenerate

endmodule

// File: rtl/tw_shift_path.sv
module tw_shift_path
    import tw_rtc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  tw_shift_ctl_t     ctl_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sd_in_i,
    output logic              tx_bit_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned TXW = 2 * DATA_W;

    logic [TXW-1:0]    tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rdata_q;

    // Command occupies the low half so it leaves first, LSB first
    always_ff @(posedge clk) begin
        if (rst)
            tx_q <= '0;
        else if (ctl_i.load)
            tx_q <= {wdata_i, cmd_i};
        else if (ctl_i.advance)
            tx_q <= tx_q >> 1;
    end

    // Receive: each sample enters at the MSB and moves right
    always_ff @(posedge clk) begin
        if (rst || ctl_i.load)
            rx_q <= '0;
        else if (ctl_i.sample)
            rx_q <= {sd_in_i, rx_q[DATA_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_i.load)
            rdata_q <= '0;
        else if (ctl_i.commit)
            rdata_q <= rx_q;
    end

    assign tx_bit_o = tx_q[0];
    assign rdata_o  = rdata_q;

    AST_LOAD_NOT_WITH_SHIFT: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |-> !ctl_i.advance && !ctl_i.sample && !ctl_i.commit); // R8

endmodule

// File: rtl/tw_frame_ctrl.sv
module tw_frame_ctrl
    import tw_rtc_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SETUP_UNITS = 1,
    parameter int unsigned GAP_UNITS   = 5,
    parameter int unsigned TAIL_UNITS  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          rd_sel_i,
    input  logic          tick_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          ce_o,
    output logic          sclk_o,
    output logic          oe_o,
    output tw_shift_ctl_t ctl_o
);
    localparam int unsigned MAXU = max3(SETUP_UNITS, GAP_UNITS, TAIL_UNITS);
    localparam int unsigned UW   = cnt_width(MAXU);
    localparam int unsigned BW   = cnt_width(DATA_W);

    localparam logic [UW-1:0] SETUP_LAST = UW'(SETUP_UNITS - 1);
    localparam logic [UW-1:0] GAP_LAST   = UW'(GAP_UNITS - 1);
    localparam logic [UW-1:0] TAIL_LAST  = UW'(TAIL_UNITS - 1);
    localparam logic [BW-1:0] BIT_LAST   = BW'(DATA_W - 1);

    tw_phase_e      phase_q;
    logic [UW-1:0]  units_q;
    logic [BW-1:0]  bit_q;
    logic           second_q;   // shifting the byte after the command
    logic           rd_q;
    logic           done_q;
    logic           unit_end;

    assign unit_end = tick_i && (units_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            units_q  <= '0;
            bit_q    <= '0;
            second_q <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q  <= PH_SETUP;
                        units_q  <= SETUP_LAST;
                        bit_q    <= '0;
                        second_q <= 1'b0;
                        rd_q     <= rd_sel_i;
                    end
                end
                PH_SETUP: begin
                    if (tick_i) begin
                        if (units_q != '0) units_q <= units_q - 1'b1;
                        else begin
                            phase_q <= PH_GAP;
                            units_q <= GAP_LAST;
                        end
                    end
                end
                PH_GAP: begin
                    if (tick_i) begin
                        if (units_q != '0) units_q <= units_q - 1'b1;
                        else phase_q <= PH_CLKLO;
                    end
                end
                PH_CLKLO: begin
                    if (unit_end) phase_q <= PH_CLKHI;
                end
                PH_CLKHI: begin
                    if (unit_end) begin
                        if (bit_q == BIT_LAST) begin
                            bit_q <= '0;
                            if (second_q) begin
                                phase_q <= PH_TAIL;
                                units_q <= TAIL_LAST;
                            end else begin
                                second_q <= 1'b1;
                                phase_q  <= PH_CLKLO;
                            end
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            phase_q <= PH_CLKLO;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tick_i) begin
                        if (units_q != '0) units_q <= units_q - 1'b1;
                        else phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= (phase_q == PH_TAIL) && unit_end;
    end

    always_comb begin
        ctl_o         = '0;
        ctl_o.load    = (phase_q == PH_IDLE) && start_i;
        ctl_o.advance = (phase_q == PH_CLKHI) && unit_end;
        ctl_o.sample  = (phase_q == PH_CLKLO) && unit_end && second_q && rd_q;
        ctl_o.commit  = (phase_q == PH_TAIL) && unit_end && rd_q;
    end

    assign busy_o = (phase_q != PH_IDLE);
    assign done_o = done_q;
    assign ce_o   = (phase_q == PH_CLKLO) || (phase_q == PH_CLKHI) || (phase_q == PH_TAIL);
    assign sclk_o = (phase_q == PH_CLKHI) || (phase_q == PH_TAIL);
    assign oe_o   = ((phase_q == PH_CLKLO) || (phase_q == PH_CLKHI)) && !(second_q && rd_q);

    AST_CLK_ON_UNIT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(sclk_o)); // R6
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_SETUP) |=> phase_q != PH_SETUP); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

endmodule

// File: rtl/tw_rtc_master.sv
module tw_rtc_master
    import tw_rtc_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 50,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SETUP_UNITS = 1,
    parameter int unsigned GAP_UNITS   = 5,
    parameter int unsigned TAIL_UNITS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ce_o,
    output logic              sclk_o,
    output logic              sd_out_o,
    output logic              sd_oe_o,
    input  logic              sd_in_i
);
    logic          tick;
    logic          tx_bit;
    logic          oe;
    tw_shift_ctl_t ctl;

    tw_unit_timer #(.TICK_DIV(TICK_DIV)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .en     (busy_o),
        .tick_o (tick)
    );

    tw_frame_ctrl #(
        .DATA_W      (DATA_W),
        .SETUP_UNITS (SETUP_UNITS),
        .GAP_UNITS   (GAP_UNITS),
        .TAIL_UNITS  (TAIL_UNITS)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .rd_sel_i (cmd_i[RD_SEL_BIT]),
        .tick_i   (tick),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .ce_o     (ce_o),
        .sclk_o   (sclk_o),
        .oe_o     (oe),
        .ctl_o    (ctl)
    );

    tw_shift_path #(.DATA_W(DATA_W)) path_i (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .cmd_i    (cmd_i),
        .wdata_i  (wdata_i),
        .sd_in_i  (sd_in_i),
        .tx_bit_o (tx_bit),
        .rdata_o  (rdata_o)
    );

    assign sd_oe_o  = oe;
    assign sd_out_o = oe ? tx_bit : 1'b0;

    AST_ENABLE_DROP_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_o) |-> done_o && !busy_o); // R7
    AST_FRAME_OPENS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_o) |-> !sclk_o && sd_oe_o); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata_o) |-> done_o || $rose(busy_o)); // R9
    AST_CLK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> ce_o); // R6

endmodule

// File: tb/tw_rtc_master_tb_top.sv
`timescale 1ns/1ps
module tw_rtc_master_tb_top;
    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] cmd_i = '0;
    logic [7:0] wdata_i = '0;
    logic       sd_in_i = 1'b0;
    logic       busy_o, done_o, ce_o, sclk_o, sd_out_o, sd_oe_o;
    logic [7:0] rdata_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tw_rtc_master #(.TICK_DIV(D), .DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .ce_o(ce_o),
        .sclk_o(sclk_o), .sd_out_o(sd_out_o), .sd_oe_o(sd_oe_o), .sd_in_i(sd_in_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One transfer with a device model; poke issues a start mid-transfer
    task automatic run_txn(input logic [7:0] cmd, input logic [7:0] wd,
                           input logic [7:0] sb, input bit poke);
        int t, rises, ce_rise, first_rise, last_rise, ce_fall, dones;
        logic [7:0] ccmd, cdata;
        bit oe_bad, prev_sclk, prev_ce, over, exp_oe;
        rises = 0; ce_rise = -1; first_rise = -1; last_rise = -1; ce_fall = -1;
        dones = 0; ccmd = '0; cdata = '0; oe_bad = 0; over = 0;
        @(negedge clk);
        start_i = 1'b1; cmd_i = cmd; wdata_i = wd; sd_in_i = sb[0];
        @(negedge clk);
        start_i = 1'b0;
        t = 1;
        chk(busy_o == 1'b1, "R8 busy after accept", busy_o, 1);
        chk(rdata_o == 8'h00, "R9 result cleared on start", rdata_o, 0);
        prev_sclk = 1'b0; prev_ce = 1'b0;
        while (!over && t < 60 * D + 40) begin
            if (ce_o && !prev_ce) ce_rise = t;
            if (sclk_o && !prev_sclk && ce_o) begin
                rises++;
                if (rises == 1) first_rise = t;
                last_rise = t;
                if (rises <= 8) ccmd[rises-1] = sd_out_o;
                else if (rises <= 16) cdata[rises-9] = sd_out_o;
                exp_oe = !(cmd[0] && rises > 8);
                if (sd_oe_o != exp_oe) oe_bad = 1;
                if (rises >= 8 && rises < 16) sd_in_i = sb[rises-8];
            end
            if (done_o) dones++;
            if (!ce_o && prev_ce) begin
                ce_fall = t;
                over = 1;
            end
            if (!over) begin
                if (poke && t == 10 * D) begin
                    start_i = 1'b1; cmd_i = ~cmd; wdata_i = ~wd;
                end else begin
                    start_i = 1'b0; cmd_i = cmd; wdata_i = wd;
                end
                prev_sclk = sclk_o; prev_ce = ce_o;
                @(negedge clk);
                t++;
            end
        end
        start_i = 1'b0;
        chk(ccmd == cmd, "R2 command bits LSB first", ccmd, cmd);
        chk(rises == 16, "R3 rising edge count", rises, 16);
        if (!cmd[0]) begin
            chk(cdata == wd, "R3 write byte LSB first", cdata, wd);
            chk(oe_bad == 0, "R3 line driven on all edges", oe_bad, 0);
            chk(rdata_o == 8'h00, "R9 write leaves result zero", rdata_o, 0);
        end else begin
            chk(oe_bad == 0, "R4 line released for read", oe_bad, 0);
            chk(rdata_o == sb, "R4 read byte assembled", rdata_o, sb);
        end
        chk(ce_rise == 1 + 6 * D, "R5 enable rise time", ce_rise, 1 + 6 * D);
        chk(first_rise == 1 + 7 * D, "R5 first clock rise", first_rise, 1 + 7 * D);
        chk(last_rise - first_rise == 30 * D, "R6 bit period", last_rise - first_rise, 30 * D);
        chk(ce_fall - last_rise == 3 * D, "R7 tail length", ce_fall - last_rise, 3 * D);
        chk(ce_fall == 1 + 40 * D, "R10 transfer length", ce_fall, 1 + 40 * D);
        chk(dones == 1 && busy_o == 1'b0 && sclk_o == 1'b0, "R8 done with enable drop",
            dones, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done single cycle", done_o, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(ce_o == 0 && sclk_o == 0 && sd_oe_o == 0, "R1 lines idle in reset",
            {ce_o, sclk_o, sd_oe_o}, 0);
        chk(busy_o == 0 && done_o == 0, "R1 handshake idle in reset", {busy_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ce_o == 0 && sclk_o == 0 && sd_oe_o == 0 && busy_o == 0 && done_o == 0,
            "R1 idle after reset", {ce_o, sclk_o, sd_oe_o, busy_o, done_o}, 0);
        chk(rdata_o == 8'h00, "R1 result zero", rdata_o, 0);

        // Sweep all register addresses, both directions
        for (int r = 0; r < 32; r++) begin
            run_txn(8'h81 | 8'(r << 1), 8'h00, 8'(r * 37 + 5), 1'b0);
            run_txn(8'h80 | 8'(r << 1), 8'(r) ^ 8'hC3, 8'h00, 1'b0);
        end
        run_txn(8'hBF, 8'h00, 8'hFF, 1'b0);
        run_txn(8'hBF, 8'h00, 8'h00, 1'b0);
        run_txn(8'hBE, 8'hFF, 8'h00, 1'b0);
        run_txn(8'hBE, 8'h00, 8'h00, 1'b0);

        // Start while busy is ignored (R8)
        run_txn(8'h85, 8'h00, 8'h96, 1'b1);
        run_txn(8'h8E, 8'h5A, 8'h00, 1'b1);

        // Result holds through idle time (R9)
        run_txn(8'hC1, 8'h00, 8'h3C, 1'b0);
        repeat (50) @(negedge clk);
        chk(rdata_o == 8'h3C, "R9 result held while idle", rdata_o, 8'h3C);
        chk(busy_o == 0 && ce_o == 0, "R9 idle between transfers", {busy_o, ce_o}, 0);
        run_txn(8'hC0, 8'h42, 8'h00, 1'b0);
        repeat (20) @(negedge clk);
        chk(rdata_o == 8'h00, "R9 zero after write", rdata_o, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule